// File: doc/BRIEF.md
# Multi-line receiver scanner

The scanner sits between a group of serial receivers and a shared receive FIFO. It visits the receivers one after another in a fixed round-robin order. Each visit takes four clock cycles, called the step, decide, count and rest phases. In the step phase, a line address advances to the next receiver. In the decide phase, the scanner checks the selected receiver's data-available flag and the FIFO's ready input. If both are true, a registered load is issued.

During the load cycle, the FIFO receives one 16-bit word. The word carries the character, the receiver's framing, overrun and parity error flags, the line number and a valid marker. In the same cycle, the serviced receiver gets a one-cycle strobe that clears its data-available flag. A load-count pulse is also raised, but only when the alarm-count enable is set. A scan-enable input parks the sequencer in the step phase and stops all loads.

Top module: `rx_line_scanner`

## Requirements
- R1: While `rst_ni` is low, and after it is released, all strobes are low and the word output is zero. The line address starts at 0, so the first line examined after enabling is line 1.
- R2: With `scan_en_i` held high, the phases repeat every four clock cycles. A load can appear only in the third cycle of a scan, and it lasts exactly one cycle.
- R3: The line address advances by one, modulo the line count, at the end of each step phase. With four lines, the visit order is 1, 2, 3, 0 and then repeats.
- R4: A load occurs only when, at the clock edge that ends the decide phase, the selected line's `avail_i` bit and `fifo_ready_i` are both high.
- R5: The load word layout is as follows: bits 7:0 hold the character, bits 9:8 the line number, bit 12 the parity error, bit 13 the framing error, bit 14 the overrun error and bit 15 a constant 1. Bits 11:10 are 0.
- R6: `avail_clr_o` is high in the load cycle on the serviced line's bit only, and is zero in every other cycle.
- R7: `load_count_o` pulses in the load cycle when `alarm_en_i` was high at the decide edge. It stays low in every other case.
- R8: When `scan_en_i` is low at a clock edge, the sequencer returns to the step phase and holds there, and no load follows. The line address is kept.
- R9: Outside a load cycle, `fifo_word_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | Runs the phase sequencer when high |
| alarm_en_i | input | 1 | Enables the load-count pulse |
| avail_i | input | 4 | Data-available flag per receiver |
| rx_data_i | input | 32 | Character per receiver, line n at bits 8n+7:8n |
| fe_i | input | 4 | Framing error per receiver |
| oe_i | input | 4 | Overrun error per receiver |
| pe_i | input | 4 | Parity error per receiver |
| fifo_ready_i | input | 1 | FIFO can accept a word |
| fifo_load_o | output | 1 | One-cycle FIFO write strobe |
| fifo_word_o | output | 16 | Word written to the FIFO |
| avail_clr_o | output | 4 | Per-line data-available clear strobe |
| load_count_o | output | 1 | Load-count pulse |

## Verification
Some properties are checked by assertions on every cycle:
- a load is never followed by another load in the next cycle;
- the clear strobe has one bit set during a load and none otherwise;
- the count pulse appears only with a load;
- the word is zero and the valid bit clear outside a load;
- a disabled cycle is never followed by a load;
- the line address moves only out of an enabled step phase.

Other behaviour needs the bench scenarios:
- the visit order;
- the exact cycle in which a load lands;
- the field placement of character, line number and error flags;
- the effect of dropping the scan enable in the middle of a scan, which skips a line.

The bench sweeps every combination of the four flags, FIFO ready and alarm enable.

// File: rtl/rls_pkg.sv
package rls_pkg;
  localparam int NUM_LINES = 4;
  localparam int DATA_W    = 8;
  localparam int WORD_W    = 16;

  typedef enum logic [1:0] {
    PH_STEP  = 2'd0,
    PH_LOAD  = 2'd1,
    PH_COUNT = 2'd2,
    PH_REST  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              fe;
    logic              oe;
    logic              pe;
  } rx_char_t;

  function automatic logic [WORD_W-1:0] pack_word(input rx_char_t c, input logic [1:0] line);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[7:0]   = c.data;
    w[9:8]   = line;
    w[12]    = c.pe;
    w[13]    = c.fe;
    w[14]    = c.oe;
    w[15]    = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/rls_sequencer.sv
module rls_sequencer #(
  parameter int NUM_LINES = rls_pkg::NUM_LINES,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scan_en_i,
  output rls_pkg::phase_e    phase_o,
  output logic [LINE_W-1:0]  addr_o
);
  import rls_pkg::*;

  localparam logic [LINE_W-1:0] LAST = LINE_W'(NUM_LINES - 1);

  phase_e             phase_q, phase_d;
  logic [LINE_W-1:0]  addr_q;

  always_comb begin
    case (phase_q)
      PH_STEP:  phase_d = PH_LOAD;
      PH_LOAD:  phase_d = PH_COUNT;
      PH_COUNT: phase_d = PH_REST;
      default:  phase_d = PH_STEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_STEP;
      addr_q  <= '0;
    end else if (!scan_en_i) begin
      phase_q <= PH_STEP;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_STEP) addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign addr_o  = addr_q;

  // R8: disabled edge parks the sequencer
  a_r8_park_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_i |=> phase_q == PH_STEP);

  // R3: address moves only out of an enabled step phase
  a_r3_addr_moves_in_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_q != $past(addr_q)) |-> ($past(phase_q) == PH_STEP && $past(scan_en_i)));
endmodule

// File: rtl/rls_select.sv
module rls_select #(
  parameter int NUM_LINES = rls_pkg::NUM_LINES,
  parameter int DATA_W    = rls_pkg::DATA_W,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic [LINE_W-1:0]           addr_i,
  input  logic [NUM_LINES-1:0]        avail_i,
  input  logic [NUM_LINES*DATA_W-1:0] rx_data_i,
  input  logic [NUM_LINES-1:0]        fe_i,
  input  logic [NUM_LINES-1:0]        oe_i,
  input  logic [NUM_LINES-1:0]        pe_i,
  output logic                        sel_avail_o,
  output rls_pkg::rx_char_t           sel_char_o
);
  import rls_pkg::*;

  rx_char_t chars [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign chars[g].data = rx_data_i[g*DATA_W +: DATA_W];
    assign chars[g].fe   = fe_i[g];
    assign chars[g].oe   = oe_i[g];
    assign chars[g].pe   = pe_i[g];
  end

  assign sel_avail_o = avail_i[addr_i];
  assign sel_char_o  = chars[addr_i];
endmodule

// File: rtl/rls_loader.sv
module rls_loader #(
  parameter int NUM_LINES = rls_pkg::NUM_LINES,
  parameter int WORD_W    = rls_pkg::WORD_W,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scan_en_i,
  input  logic                  alarm_en_i,
  input  rls_pkg::phase_e       phase_i,
  input  logic [LINE_W-1:0]     addr_i,
  input  logic                  sel_avail_i,
  input  rls_pkg::rx_char_t     sel_char_i,
  input  logic                  fifo_ready_i,
  output logic                  load_o,
  output logic [WORD_W-1:0]     word_o,
  output logic [NUM_LINES-1:0]  clr_o,
  output logic                  count_o
);
  import rls_pkg::*;

  logic                 take;
  logic [NUM_LINES-1:0] clr_d;
  logic                 load_q, cnt_q;
  logic [WORD_W-1:0]    word_q;
  logic [NUM_LINES-1:0] clr_q;

  assign take = scan_en_i && (phase_i == PH_LOAD) && sel_avail_i && fifo_ready_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_clr
    assign clr_d[g] = take && (addr_i == LINE_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      cnt_q  <= 1'b0;
      word_q <= '0;
      clr_q  <= '0;
    end else begin
      load_q <= take;
      cnt_q  <= take && alarm_en_i;
      word_q <= take ? pack_word(sel_char_i, 2'(addr_i)) : '0;
      clr_q  <= clr_d;
    end
  end

  assign load_o  = load_q;
  assign word_o  = word_q;
  assign clr_o   = clr_q;
  assign count_o = cnt_q;

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |=> !load_q);
  a_r4_from_decide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> ($past(phase_i) == PH_LOAD && $past(fifo_ready_i)));
  a_r6_clr_one_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> $countones(clr_q) == 1);
  a_r6_clr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_q |-> clr_q == '0);
  a_r7_count_with_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q |-> load_q);
  a_r5_valid_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> (word_q[15] && word_q[11:10] == 2'b00));
  a_r9_zero_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_q |-> word_q == '0);
  a_r8_no_load_after_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!scan_en_i) |-> !load_q);
endmodule

// File: rtl/rx_line_scanner.sv
module rx_line_scanner #(
  parameter int NUM_LINES = rls_pkg::NUM_LINES,
  parameter int DATA_W    = rls_pkg::DATA_W,
  parameter int WORD_W    = rls_pkg::WORD_W,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        scan_en_i,
  input  logic                        alarm_en_i,
  input  logic [NUM_LINES-1:0]        avail_i,
  input  logic [NUM_LINES*DATA_W-1:0] rx_data_i,
  input  logic [NUM_LINES-1:0]        fe_i,
  input  logic [NUM_LINES-1:0]        oe_i,
  input  logic [NUM_LINES-1:0]        pe_i,
  input  logic                        fifo_ready_i,
  output logic                        fifo_load_o,
  output logic [WORD_W-1:0]           fifo_word_o,
  output logic [NUM_LINES-1:0]        avail_clr_o,
  output logic                        load_count_o
);
  import rls_pkg::*;

  phase_e            phase;
  logic [LINE_W-1:0] addr;
  logic              sel_avail;
  rx_char_t          sel_char;

  rls_sequencer #(.NUM_LINES(NUM_LINES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scan_en_i (scan_en_i),
    .phase_o   (phase),
    .addr_o    (addr)
  );

  rls_select #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_sel (
    .addr_i      (addr),
    .avail_i     (avail_i),
    .rx_data_i   (rx_data_i),
    .fe_i        (fe_i),
    .oe_i        (oe_i),
    .pe_i        (pe_i),
    .sel_avail_o (sel_avail),
    .sel_char_o  (sel_char)
  );

  rls_loader #(.NUM_LINES(NUM_LINES), .WORD_W(WORD_W)) u_load (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .scan_en_i    (scan_en_i),
    .alarm_en_i   (alarm_en_i),
    .phase_i      (phase),
    .addr_i       (addr),
    .sel_avail_i  (sel_avail),
    .sel_char_i   (sel_char),
    .fifo_ready_i (fifo_ready_i),
    .load_o       (fifo_load_o),
    .word_o       (fifo_word_o),
    .clr_o        (avail_clr_o),
    .count_o      (load_count_o)
  );
endmodule

// File: tb/rx_line_scanner_bench.sv
module rx_line_scanner_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        scan_en, alarm_en, fifo_ready;
  logic [3:0]  avail, fe, oe, pe;
  logic [31:0] rx_data;
  logic        fifo_load, load_count;
  logic [15:0] fifo_word;
  logic [3:0]  avail_clr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int ph     = 0;
  int line   = 0;

  always #10 clk = ~clk;

  rx_line_scanner u_rx_line_scanner (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scan_en_i    (scan_en),
    .alarm_en_i   (alarm_en),
    .avail_i      (avail),
    .rx_data_i    (rx_data),
    .fe_i         (fe),
    .oe_i         (oe),
    .pe_i         (pe),
    .fifo_ready_i (fifo_ready),
    .fifo_load_o  (fifo_load),
    .fifo_word_o  (fifo_word),
    .avail_clr_o  (avail_clr),
    .load_count_o (load_count)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_cycle();
    bit          en, rdy, al, exp_load, exp_cnt, decide;
    logic [3:0]  av, f, o, p, exp_clr;
    logic [31:0] d;
    logic [15:0] exp_word;
    string       ltag;
    en = scan_en; rdy = fifo_ready; al = alarm_en;
    av = avail; f = fe; o = oe; p = pe; d = rx_data;
    exp_load = 1'b0; decide = 1'b0;
    @(posedge clk);
    if (en) begin
      if (ph == 0) line = (line + 1) % 4;
      if (ph == 1) begin
        decide   = 1'b1;
        exp_load = av[line] && rdy;
      end
      ph = (ph + 1) % 4;
    end else begin
      ph = 0;
    end
    exp_cnt  = exp_load && al;
    exp_clr  = exp_load ? (4'b0001 << line) : 4'b0000;
    exp_word = exp_load ? {1'b1, o[line], f[line], p[line], 2'b00, 2'(line), d[line*8 +: 8]} : 16'h0;
    ltag = !en ? "R8" : (decide ? "R4" : "R2");
    @(negedge clk);
    chk(fifo_load == exp_load, ltag, "fifo_load_o", int'(fifo_load), int'(exp_load));
    chk(fifo_word == exp_word, exp_load ? "R5" : "R9", "fifo_word_o", int'(fifo_word), int'(exp_word));
    if (exp_load)
      chk(fifo_word[9:8] == 2'(line), "R3", "line field", int'(fifo_word[9:8]), line);
    chk(avail_clr == exp_clr, "R6", "avail_clr_o", int'(avail_clr), int'(exp_clr));
    chk(load_count == exp_cnt, "R7", "load_count_o", int'(load_count), int'(exp_cnt));
    avail = avail & ~avail_clr;  // receiver drops its flag on the clear strobe
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scan_en = 1'b1; alarm_en = 1'b1; fifo_ready = 1'b1;
    avail = 4'hF; fe = 4'h0; oe = 4'h0; pe = 4'h0;
    rx_data = 32'h44332211;
    repeat (3) @(negedge clk);
    // R1: reset holds every output low
    chk(fifo_load == 1'b0 && avail_clr == 4'h0 && load_count == 1'b0, "R1", "strobes in reset",
        int'({fifo_load, avail_clr, load_count}), 0);
    chk(fifo_word == 16'h0, "R1", "word in reset", int'(fifo_word), 0);
    rst_n = 1'b1;
    run_cycle();
    run_cycle();
    // R1: first serviced line after reset is line 1
    chk(fifo_load && fifo_word[9:8] == 2'd1, "R1", "first line", int'(fifo_word[9:8]), 1);
    run_cycle(); run_cycle();
    repeat (12) run_cycle();
    chk(avail == 4'h0, "R6", "all flags cleared", int'(avail), 0);

    // Sweep flags, ready, alarm and error bits, one scan per pattern
    for (int pat = 0; pat < 64; pat++) begin
      avail      = 4'(pat);
      fifo_ready = pat[4];
      alarm_en   = pat[5];
      fe = {pat[0], pat[1], pat[2], pat[3]};
      oe = 4'(pat) ^ 4'hA;
      pe = 4'(pat >> 2);
      for (int l = 0; l < 4; l++) rx_data[l*8 +: 8] = 8'(pat * 29 + l * 67);
      repeat (4) run_cycle();
    end

    // R8: disabled sequencer loads nothing
    avail = 4'hF; fifo_ready = 1'b1; alarm_en = 1'b1; scan_en = 1'b0;
    repeat (10) run_cycle();
    chk(avail == 4'hF, "R8", "flags untouched while off", int'(avail), 15);
    scan_en = 1'b1;
    repeat (8) run_cycle();
    // R8: drop enable right after a step phase, skipping that line
    avail = 4'hF;
    run_cycle();
    scan_en = 1'b0;
    repeat (3) run_cycle();
    scan_en = 1'b1;
    repeat (16) run_cycle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule